// File: doc/BRIEF.md
# Two-Key Watchdog with Timebase

This block is a memory-mapped watchdog for a processor subsystem. It holds a free-running 32-bit timebase that software may read at any time, and a watchdog interval counter that only runs while two enable bits are both set. These enable bits sit in two different control words, so one stray write cannot start or stop the dog. The interval lasts 2^INTERVAL_LOG2 clock cycles.

The watchdog works in two stages. When the first interval runs out, the block raises an interrupt and sets a warning flag, which gives software time to react. If the warning flag is still set when a second interval runs out, the block pulses a system reset for one cycle and records that event in a sticky status flag. Software services the dog (keepalive) by writing 1 to the warning or reset-status bit. That write clears the bit and restarts the interval. When ENABLE_ONCE is 1, the enable bits cannot be cleared once both are set.

The control FSM has four states. DISARMED: the counter is held at zero. WATCH: the first interval is running. WARNED: the interrupt is high and the second interval is running. BITE: the one-cycle reset pulse.
- DISARMED to WATCH when both enables are 1.
- WATCH to WARNED on expiry.
- WARNED to BITE on expiry.
- WATCH or WARNED to WATCH on a keepalive, which wins over a same-cycle expiry.
- WATCH or WARNED to DISARMED when either enable is 0, which wins over everything else.
- BITE to WATCH if still armed, otherwise to DISARMED.

Top module: `dual_arm_watchdog`

## Requirements
- R1: Byte offsets are 0x0 for control word A, 0x4 for control word B and 0x8 for the timebase. Control word A reads: bit 3 reset-status, bit 2 warning flag, bit 1 enable A. Control word B reads: bit 0 enable B. All other bits read 0. Any other address, including one with the low two bits nonzero, reads 0 and ignores writes. After reset both control words read 0.
- R2: With only one of the two enables set, the interval never runs and the interrupt stays low.
- R3: The interrupt and warning flag first rise 2^INTERVAL_LOG2+1 cycles after the clock edge that completes the arming. Arming means both enables become 1. Control word A then reads 0x6.
- R4: Without a keepalive, the system reset output pulses high for exactly one cycle, 2^INTERVAL_LOG2 cycles after the interrupt rose. It is high only after a cycle in which the interrupt was high.
- R5: The reset-status bit reads 1 from the cycle after the reset pulse. It stays 1 until a write to control word A with bit 3 = 1 clears it. If that clear write falls in the same cycle as the set, the set wins.
- R6: A keepalive is a write to control word A with bit 2 or bit 3 = 1 while armed. It drops the interrupt and warning flag on the next cycle. The next interrupt then comes exactly 2^INTERVAL_LOG2 cycles after the keepalive edge.
- R7: A keepalive on the same edge as an expiry wins. No warning is raised and no reset is pulsed.
- R8: Writing 0 to bit 2 or bit 3 of control word A has no effect on those flags or on the interrupt.
- R9: Clearing either enable stops the interval. The interrupt and warning flag drop by the second cycle after the write, and no reset follows.
- R10: The timebase at offset 0x8 increments by exactly one every clock cycle.
- R11: With ENABLE_ONCE = 1, the enable bits can be written freely until both are 1. From then on, writes of 0 to them are ignored and the interval keeps running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 4 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| wdt_irq | output | 1 | Watchdog warning interrupt |
| sys_rst_out | output | 1 | One-cycle system reset pulse |

## Verification
Two collisions matter most. The first is a keepalive landing on the same edge as an interval expiry. The bench sweeps the keepalive over every cycle offset from the arming edge up to the second expiry, which hits the first expiry (offset 2^N+1) and the second expiry (offset 2^(N+1)+1) exactly. At each offset it checks that the interrupt is low just after the write, that it returns exactly 2^N cycles later, and that no reset pulse ever appears. The second collision is a reset-status clear written on the edge where the flag is being set. The bench aims that write at the edge right after the observed reset pulse and expects the flag to read 1.

// File: rtl/dawd_pkg.sv
package dawd_pkg;

    typedef enum logic [1:0] {
        ST_DISARMED = 2'd0,
        ST_WATCH    = 2'd1,
        ST_WARNED   = 2'd2,
        ST_BITE     = 2'd3
    } wd_state_e;

    localparam int BUS_W  = 32;
    localparam int ADDR_W = 4;

    localparam logic [1:0] IDX_CTRL_A = 2'd0;
    localparam logic [1:0] IDX_CTRL_B = 2'd1;
    localparam logic [1:0] IDX_TBASE  = 2'd2;

    localparam int BIT_RSTAT = 3;
    localparam int BIT_WARN  = 2;
    localparam int BIT_EN_A  = 1;
    localparam int BIT_EN_B  = 0;

endpackage

// File: rtl/dawd_timebase.sv
module dawd_timebase #(
    parameter int TB_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [TB_W-1:0] tb_count
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tb_count <= '0;
        end else begin
            tb_count <= tb_count + {{(TB_W-1){1'b0}}, 1'b1};
        end
    end

endmodule

// File: rtl/dawd_interval.sv
module dawd_interval #(
    parameter int LOG2 = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic expire
);

    localparam logic [LOG2-1:0] LAST = {LOG2{1'b1}};

    logic [LOG2-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || restart) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + {{(LOG2-1){1'b0}}, 1'b1};
        end
    end

    always_comb begin
        expire = run && !restart && (cnt == LAST);
    end

endmodule

// File: rtl/dawd_fsm.sv
module dawd_fsm
    import dawd_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      armed,
    input  logic      keepalive,
    input  logic      expire,
    output wd_state_e state,
    output logic      warn_flag,
    output logic      bite,
    output logic      run,
    output logic      restart
);

    wd_state_e state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_DISARMED;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_DISARMED: begin
                if (armed) state_nx = ST_WATCH;
            end
            ST_WATCH: begin
                if (!armed)         state_nx = ST_DISARMED;
                else if (keepalive) state_nx = ST_WATCH;
                else if (expire)    state_nx = ST_WARNED;
            end
            ST_WARNED: begin
                if (!armed)         state_nx = ST_DISARMED;
                else if (keepalive) state_nx = ST_WATCH;
                else if (expire)    state_nx = ST_BITE;
            end
            ST_BITE: begin
                state_nx = armed ? ST_WATCH : ST_DISARMED;
            end
        endcase
    end

    always_comb begin
        warn_flag = 1'b0;
        bite      = 1'b0;
        run       = 1'b0;
        unique case (state)
            ST_DISARMED: ;
            ST_WATCH:    run = 1'b1;
            ST_WARNED: begin
                run       = 1'b1;
                warn_flag = 1'b1;
            end
            ST_BITE:     bite = 1'b1;
        endcase
        restart = keepalive && run;
    end

endmodule

// File: rtl/dawd_regs.sv
module dawd_regs
    import dawd_pkg::*;
#(
    parameter bit ENABLE_ONCE = 1'b0,
    parameter int TB_W        = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  logic              warn_flag,
    input  logic              bite,
    input  logic [TB_W-1:0]   tb_count,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              armed,
    output logic              keepalive,
    output logic              rstat
);

    localparam int IDX_LSB = 2;

    logic       aligned;
    logic [1:0] idx;
    logic       wr_a;
    logic       wr_b;
    logic       en_a;
    logic       en_b;
    logic       hold;
    logic       unused_wdata_bits;

    assign unused_wdata_bits = ^bus_wdata[BUS_W-1:BIT_RSTAT+1];

    always_comb begin
        aligned = (bus_addr[IDX_LSB-1:0] == '0);
        idx     = bus_addr[ADDR_W-1:IDX_LSB];
        wr_a    = bus_wr && aligned && (idx == IDX_CTRL_A);
        wr_b    = bus_wr && aligned && (idx == IDX_CTRL_B);
        armed   = en_a && en_b;
        keepalive = wr_a && (bus_wdata[BIT_WARN] || bus_wdata[BIT_RSTAT]);
    end

    generate
        if (ENABLE_ONCE) begin : g_sticky
            assign hold = armed;
        end else begin : g_free
            assign hold = 1'b0;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_a <= 1'b0;
            en_b <= 1'b0;
        end else begin
            if (wr_a) en_a <= bus_wdata[BIT_EN_A] || hold;
            if (wr_b) en_b <= bus_wdata[BIT_EN_B] || hold;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rstat <= 1'b0;
        end else if (bite) begin
            rstat <= 1'b1;
        end else if (wr_a && bus_wdata[BIT_RSTAT]) begin
            rstat <= 1'b0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            unique case (idx)
                IDX_CTRL_A: begin
                    bus_rdata[BIT_RSTAT] = rstat;
                    bus_rdata[BIT_WARN]  = warn_flag;
                    bus_rdata[BIT_EN_A]  = en_a;
                end
                IDX_CTRL_B: bus_rdata[BIT_EN_B] = en_b;
                IDX_TBASE:  bus_rdata[TB_W-1:0] = tb_count;
                default:    bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/dual_arm_watchdog.sv
module dual_arm_watchdog
    import dawd_pkg::*;
#(
    parameter int INTERVAL_LOG2 = 16,
    parameter bit ENABLE_ONCE   = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              wdt_irq,
    output logic              sys_rst_out
);

    localparam int TB_W = BUS_W;

    logic [TB_W-1:0] tb_count;
    logic            armed;
    logic            keepalive;
    logic            rstat;
    logic            expire;
    logic            warn_flag;
    logic            bite;
    logic            run;
    logic            restart;
    wd_state_e       state;

    dawd_timebase #(.TB_W(TB_W)) u_tbase (
        .clk      (clk),
        .rst_n    (rst_n),
        .tb_count (tb_count)
    );

    dawd_regs #(.ENABLE_ONCE(ENABLE_ONCE), .TB_W(TB_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .warn_flag (warn_flag),
        .bite      (bite),
        .tb_count  (tb_count),
        .bus_rdata (bus_rdata),
        .armed     (armed),
        .keepalive (keepalive),
        .rstat     (rstat)
    );

    dawd_interval #(.LOG2(INTERVAL_LOG2)) u_ival (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .restart (restart),
        .expire  (expire)
    );

    dawd_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .armed     (armed),
        .keepalive (keepalive),
        .expire    (expire),
        .state     (state),
        .warn_flag (warn_flag),
        .bite      (bite),
        .run       (run),
        .restart   (restart)
    );

    assign wdt_irq     = warn_flag;
    assign sys_rst_out = bite;

endmodule

// File: rtl/dawd_checker.sv
module dawd_checker #(
    parameter bit ENABLE_ONCE = 1'b0
) (
    input logic        clk,
    input logic        rst_n,
    input logic        irq,
    input logic        sys_rst,
    input logic        armed,
    input logic        rstat,
    input logic [31:0] tb
);

    p_irq_needs_arm_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(armed));

    p_rst_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst |=> !sys_rst);

    p_rst_after_warn_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst) |-> $past(irq));

    p_rstat_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst |=> rstat);

    p_disarm_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |=> !irq);

    p_tb_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (tb == $past(tb) + 32'd1));

    generate
        if (ENABLE_ONCE) begin : g_once
            p_arm_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
                $past(armed) |-> armed);
        end
    endgenerate

endmodule

bind dual_arm_watchdog dawd_checker #(.ENABLE_ONCE(ENABLE_ONCE)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq     (wdt_irq),
    .sys_rst (sys_rst_out),
    .armed   (armed),
    .rstat   (rstat),
    .tb      (tb_count)
);

// File: tb/dual_arm_watchdog_test.sv
module dual_arm_watchdog_test;

    localparam int LOG2 = 4;
    localparam int IVAL = 1 << LOG2;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n;
    logic [3:0]  a_addr, b_addr;
    logic        a_wr, b_wr;
    logic [31:0] a_wdata, b_wdata, a_rdata, b_rdata;
    logic        a_irq, b_irq, a_rst, b_rst;

    int checks = 0;
    int fails = 0;
    int rst_seen = 0;
    int cyc = 0;

    dual_arm_watchdog #(.INTERVAL_LOG2(LOG2), .ENABLE_ONCE(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(a_addr), .bus_wr(a_wr),
        .bus_wdata(a_wdata), .bus_rdata(a_rdata), .wdt_irq(a_irq), .sys_rst_out(a_rst));

    dual_arm_watchdog #(.INTERVAL_LOG2(LOG2), .ENABLE_ONCE(1'b1)) uut_once (
        .clk(clk), .rst_n(rst_n), .bus_addr(b_addr), .bus_wr(b_wr),
        .bus_wdata(b_wdata), .bus_rdata(b_rdata), .wdt_irq(b_irq), .sys_rst_out(b_rst));

    always @(negedge clk) if (a_rst) rst_seen++;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog expired actual=%0d expected<=150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wa(input logic [3:0] ad, input logic [31:0] d);
        a_addr = ad; a_wdata = d; a_wr = 1'b1;
        @(negedge clk);
        a_wr = 1'b0;
    endtask

    task automatic wb(input logic [3:0] ad, input logic [31:0] d);
        b_addr = ad; b_wdata = d; b_wr = 1'b1;
        @(negedge clk);
        b_wr = 1'b0;
    endtask

    task automatic ra(input logic [3:0] ad, output logic [31:0] d);
        a_addr = ad; #1; d = a_rdata;
    endtask

    task automatic rb(input logic [3:0] ad, output logic [31:0] d);
        b_addr = ad; #1; d = b_rdata;
    endtask

    task automatic wait_irq_a(output int k);
        k = 0;
        while (!a_irq && k < 200) begin @(negedge clk); k++; end
    endtask

    task automatic wait_rst_a(output int k);
        k = 0;
        while (!a_rst && k < 200) begin @(negedge clk); k++; end
    endtask

    task automatic arm_a();
        wa(4'h4, 32'h1);
        wa(4'h0, 32'h2);
    endtask

    task automatic disarm_a();
        wa(4'h0, 32'hC);
        wa(4'h4, 32'h0);
        @(negedge clk);
    endtask

    initial begin
        int k;
        int base;
        logic [31:0] v, t1;
        rst_n = 1'b0;
        a_addr = '0; a_wr = 1'b0; a_wdata = '0;
        b_addr = '0; b_wr = 1'b0; b_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state and map
        ra(4'h0, v); check("R1 ctrl A reset", v, 32'h0);
        ra(4'h4, v); check("R1 ctrl B reset", v, 32'h0);
        ra(4'hC, v); check("R1 unmapped", v, 32'h0);
        check("R1 irq reset", a_irq, 1'b0);
        check("R1 rst reset", a_rst, 1'b0);
        wa(4'h0, 32'hFFFF_FFF2);
        ra(4'h0, v); check("R1 ctrl A readback", v, 32'h2);
        ra(4'h1, v); check("R1 unaligned reads 0", v, 32'h0);
        repeat (3*IVAL) @(negedge clk);
        check("R2 only enable A", a_irq, 1'b0);
        wa(4'h0, 32'h0);
        wa(4'h5, 32'h1);
        ra(4'h4, v); check("R1 unaligned write ignored", v, 32'h0);
        wa(4'h4, 32'hFFFF_FFFF);
        ra(4'h4, v); check("R1 ctrl B readback", v, 32'h1);
        repeat (3*IVAL) @(negedge clk);
        check("R2 only enable B", a_irq, 1'b0);
        wa(4'h4, 32'h0);

        // R3 R4 R5 R8: full two-stage run
        arm_a();
        wait_irq_a(k); check("R3 first expiry time", k, IVAL+1);
        ra(4'h0, v); check("R3 ctrl A warned", v, 32'h6);
        wait_rst_a(k); check("R4 second expiry time", k, IVAL);
        @(negedge clk);
        check("R4 pulse one cycle", a_rst, 1'b0);
        ra(4'h0, v); check("R5 status set", v, 32'hA);
        wa(4'h0, 32'h2);
        ra(4'h0, v); check("R8 zero write keeps status", v, 32'hA);
        wa(4'h0, 32'hA);
        ra(4'h0, v); check("R5 status cleared", v, 32'h2);
        disarm_a();

        // R6 R7: keepalive swept over every offset incl. both expiries
        for (int d = 1; d <= 2*IVAL+1; d++) begin
            base = rst_seen;
            arm_a();
            repeat (d-1) @(negedge clk);
            wa(4'h0, 32'h6);
            check((d == IVAL+1 || d == 2*IVAL+1) ? "R7 collision irq low" : "R6 irq low",
                  a_irq, 1'b0);
            wait_irq_a(k);
            check((d == IVAL+1 || d == 2*IVAL+1) ? "R7 collision restart" : "R6 restart",
                  k, IVAL);
            disarm_a();
            check("R7 no reset pulse", rst_seen, base);
        end

        // R8 R9: zero writes, then disarm while warned
        arm_a();
        wait_irq_a(k);
        wa(4'h0, 32'h2);
        check("R8 irq kept", a_irq, 1'b1);
        ra(4'h0, v); check("R8 flag kept", v, 32'h6);
        base = rst_seen;
        wa(4'h4, 32'h0);
        @(negedge clk);
        check("R9 irq dropped", a_irq, 1'b0);
        ra(4'h0, v); check("R9 flag dropped", v, 32'h2);
        repeat (3*IVAL) @(negedge clk);
        check("R9 no irq after disarm", a_irq, 1'b0);
        check("R9 no reset after disarm", rst_seen, base);
        wa(4'h0, 32'hC);

        // R5: clear colliding with set
        arm_a();
        wait_irq_a(k);
        wait_rst_a(k);
        wa(4'h0, 32'hA);
        ra(4'h0, v); check("R5 set wins over clear", v & 32'h8, 32'h8);
        wa(4'h0, 32'hA);
        ra(4'h0, v); check("R5 later clear", v, 32'h2);
        disarm_a();

        // R10 timebase
        ra(4'h8, t1);
        repeat (5) @(negedge clk);
        ra(4'h8, v); check("R10 step five", v - t1, 32'd5);
        @(negedge clk);
        ra(4'h8, t1); check("R10 step one", t1 - v, 32'd1);

        // R11 enable-once
        wb(4'h0, 32'h2);
        wb(4'h0, 32'h0);
        rb(4'h0, v); check("R11 free before arming", v, 32'h0);
        wb(4'h4, 32'h1);
        wb(4'h0, 32'h2);
        wb(4'h0, 32'h0);
        wb(4'h4, 32'h0);
        rb(4'h0, v); check("R11 enable A held", v & 32'h2, 32'h2);
        rb(4'h4, v); check("R11 enable B held", v, 32'h1);
        k = 0;
        while (!b_irq && k < 200) begin @(negedge clk); k++; end
        check("R11 interval still runs", b_irq, 1'b1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule